// File: doc/BRIEF.md
# Square-and-Compare Base-2 Logarithm Unit

This block takes an unsigned integer, typically a measured signal power, and returns its base-2 logarithm as an unsigned fixed-point number. The integer field of the result is the bit index of the input's leading one. The fraction field is found one bit per clock cycle by a square-and-compare loop. First the input is shifted so that its leading one becomes the units bit of a mantissa in [1,2). Each step then squares that mantissa. The step emits a 1 when the square reaches 2, in which case it halves the square, and emits a 0 otherwise. The result is cut back to a fixed mantissa width so that the multiplier stays bounded.

The block is used with a start/busy/done handshake. The caller presents a value with a one-cycle start pulse while the unit is idle. It then waits for the single-cycle done pulse, which marks a valid result and error flag. A zero input has no logarithm. It follows the same timing, but raises the error flag and returns the all-zero code.

Top module: `log2sq_unit`

## Requirements
- R1: While reset is held, and after it is released, busy, done and error are low and result is zero.
- R2: A start high on a clock edge while busy is low captures din and raises busy. A start while busy is high has no effect on the running computation, its result or its timing.
- R3: Done is high for exactly one cycle, FRAC_BITS clock edges after the edge that accepted start. Busy stays high from the accepting edge until the edge that raises done, and done is never high together with busy.
- R4: The integer field, which is the upper INT_W = clog2(IN_W) bits of result, equals the index of the most significant set bit of din.
- R5: The starting mantissa has MANT_FW fraction bits and holds din shifted so that its leading one sits at bit MANT_FW. When the leading-one index exceeds MANT_FW, the bits shifted out below are dropped.
- R6: Fraction bits are produced most significant first. In each step the mantissa m is squared to s = m*m, which has 2*MANT_FW fraction bits. If s >= 2, the bit is 1 and the new mantissa is s/2. Otherwise the bit is 0 and the new mantissa is s. In both cases the new mantissa is truncated to MANT_FW fraction bits.
- R7: result is {integer field, fraction field}, and the fraction occupies the low FRAC_BITS bits.
- R8: A zero din gives error high and result zero, with the same latency as any other input. A later nonzero operation clears error at its done.
- R9: result and error keep their values from one done pulse until the next done pulse.
- R10: A power-of-two din gives an all-zero fraction field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a conversion of din |
| din | input | IN_W | Unsigned operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: result and error are fresh |
| error | output | 1 | Operand of the latest finished conversion was zero |
| result | output | INT_W+FRAC_BITS | Base-2 logarithm, integer field above fraction field |

## Verification
After the edge that accepts start, busy is due at the very next sample point. Done, result and error are due exactly FRAC_BITS edges later. The bench raises start at a falling edge and then counts falling-edge samples until done appears. It requires that count to equal FRAC_BITS and reads result and error in that same sample. One sample later it confirms that done has dropped. The exhaustive sweep uses a small configuration in which leading-one indices both below and above the mantissa width occur. Each result is compared against an arithmetic model of the square-and-compare recurrence that the bench computes on its own.

// File: rtl/log2sq_pkg.sv
package log2sq_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } log2sq_state_e;

   // width needed to hold a bit index of an n-bit word
   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // width needed to count from 0 up to n inclusive
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/log2sq_lead_enc.sv
module log2sq_lead_enc #(
   parameter int IN_W  = 16,
   parameter int POS_W = 4
) (
   input  logic [IN_W-1:0]  din,
   output logic [POS_W-1:0] pos,
   output logic             any
);

   if (POS_W < $clog2(IN_W)) begin : g_bad_pos_w
      $error("log2sq_lead_enc: POS_W too narrow for IN_W");
   end

   // highest set bit wins: later iterations overwrite earlier ones
   always_comb begin
      pos = '0;
      any = 1'b0;
      for (int i = 0; i < IN_W; i++) begin
         if (din[i]) begin
            pos = POS_W'(i);
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/log2sq_norm.sv
module log2sq_norm #(
   parameter int IN_W    = 16,
   parameter int POS_W   = 4,
   parameter int MANT_FW = 16,
   localparam int MW     = MANT_FW + 1,
   localparam int XW     = (IN_W > MW) ? IN_W : MW
) (
   input  logic [IN_W-1:0]  din,
   input  logic [POS_W-1:0] pos,
   output logic [MW-1:0]    mant
);

   if (IN_W - 1 <= MANT_FW) begin : g_left_only
      // every leading-one index fits: only left shifts are needed
      logic [MW-1:0] ext;
      assign ext = MW'(din);
      always_comb mant = ext << (MANT_FW - int'(pos));
   end else begin : g_both_ways
      // wide operand: high indices shift right and drop low bits
      logic [XW-1:0] ext;
      assign ext = XW'(din);
      always_comb begin
         if (int'(pos) <= MANT_FW) begin
            mant = MW'(ext << (MANT_FW - int'(pos)));
         end else begin
            mant = MW'(ext >> (int'(pos) - MANT_FW));
         end
      end
   end

endmodule

// File: rtl/log2sq_step.sv
module log2sq_step #(
   parameter int MANT_FW = 16,
   localparam int MW     = MANT_FW + 1,
   localparam int SW     = 2 * MW
) (
   input  logic [MW-1:0] mant_in,
   output logic          bit_out,
   output logic [MW-1:0] mant_out
);

   logic [SW-1:0] sq;

   // square of a [1,2) value lies in [1,4); top bit carries weight 2
   assign sq      = SW'(mant_in) * SW'(mant_in);
   assign bit_out = sq[SW-1];

   always_comb begin
      if (bit_out) begin
         mant_out = sq[SW-1:MW];
      end else begin
         mant_out = sq[SW-2:MW-1];
      end
   end

endmodule

// File: rtl/log2sq_unit.sv
module log2sq_unit
   import log2sq_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int FRAC_BITS = 8,
   parameter int MANT_FW   = 16,
   localparam int INT_W    = idx_width(IN_W),
   localparam int RES_W    = INT_W + FRAC_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IN_W-1:0]  din,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic [RES_W-1:0] result
);

   localparam int MW = MANT_FW + 1;
   localparam int CW = cnt_width(FRAC_BITS);

   if (IN_W < 2) begin : g_bad_in_w
      $error("log2sq_unit: IN_W must be at least 2");
   end
   if (FRAC_BITS < 1) begin : g_bad_frac
      $error("log2sq_unit: FRAC_BITS must be at least 1");
   end
   if (MANT_FW < FRAC_BITS) begin : g_bad_mant
      $error("log2sq_unit: MANT_FW must not be below FRAC_BITS");
   end

   log2sq_state_e      state_q;
   logic [CW-1:0]      cnt_q;
   logic [MW-1:0]      mant_q;
   logic [FRAC_BITS-1:0] frac_q;
   logic [INT_W-1:0]   int_q;
   logic               zero_q;
   logic               done_q;
   logic               err_out_q;
   logic [RES_W-1:0]   res_q;

   logic [INT_W-1:0]   lead_pos;
   logic               lead_any;
   logic [MW-1:0]      norm_mant;
   logic               step_bit;
   logic [MW-1:0]      step_mant;
   logic [FRAC_BITS-1:0] frac_next;
   logic               accept;
   logic               last_step;

   log2sq_lead_enc #(
      .IN_W  (IN_W),
      .POS_W (INT_W)
   ) i_lead (
      .din (din),
      .pos (lead_pos),
      .any (lead_any)
   );

   log2sq_norm #(
      .IN_W    (IN_W),
      .POS_W   (INT_W),
      .MANT_FW (MANT_FW)
   ) i_norm (
      .din  (din),
      .pos  (lead_pos),
      .mant (norm_mant)
   );

   log2sq_step #(
      .MANT_FW (MANT_FW)
   ) i_step (
      .mant_in  (mant_q),
      .bit_out  (step_bit),
      .mant_out (step_mant)
   );

   assign accept    = start && (state_q == ST_IDLE);
   assign last_step = (state_q == ST_RUN) && (cnt_q == CW'(FRAC_BITS - 1));

   if (FRAC_BITS == 1) begin : g_frac_one
      assign frac_next = step_bit;
   end else begin : g_frac_many
      assign frac_next = {frac_q[FRAC_BITS-2:0], step_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         mant_q    <= '0;
         frac_q    <= '0;
         int_q     <= '0;
         zero_q    <= 1'b0;
         done_q    <= 1'b0;
         err_out_q <= 1'b0;
         res_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            mant_q  <= norm_mant;
            frac_q  <= '0;
            int_q   <= lead_pos;
            zero_q  <= !lead_any;
         end else if (state_q == ST_RUN) begin
            mant_q <= step_mant;
            frac_q <= frac_next;
            cnt_q  <= cnt_q + CW'(1);
            if (last_step) begin
               state_q   <= ST_IDLE;
               done_q    <= 1'b1;
               err_out_q <= zero_q;
               res_q     <= zero_q ? '0 : {int_q, frac_next};
            end
         end
      end
   end

   assign busy   = (state_q == ST_RUN);
   assign done   = done_q;
   assign error  = err_out_q;
   assign result = res_q;

   AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                            // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                       // R3
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);                                                       // R3
   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(cnt_q) < FRAC_BITS));                                   // R3
   AST_MANT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !zero_q) |-> mant_q[MW-1]);                                   // R5
   AST_ZERO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && error) |-> (result == '0));                                   // R8
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(result) && $stable(error)));                        // R9

endmodule

// File: tb/test_log2sq_unit.sv
module test_log2sq_unit;

   localparam int CLK_PERIOD = 10;
   localparam int TIW = 10;
   localparam int TFB = 6;
   localparam int TMF = 8;
   localparam int TINT = $clog2(TIW);
   localparam int TRW = TINT + TFB;
   localparam int WATCHDOG = 150000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [TIW-1:0] din = '0;
   logic           busy;
   logic           done;
   logic           error;
   logic [TRW-1:0] result;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   log2sq_unit #(
      .IN_W      (TIW),
      .FRAC_BITS (TFB),
      .MANT_FW   (TMF)
   ) i_log2sq_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .din    (din),
      .busy   (busy),
      .done   (done),
      .error  (error),
      .result (result)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // arithmetic model of the requirements
   function automatic longint model(input longint x);
      longint p, m, s, f;
      p = 0;
      for (int i = 0; i < TIW; i++) if ((x >> i) & 1) p = i;
      if (x == 0) return 0;
      m = (p <= TMF) ? (x << (TMF - p)) : (x >> (p - TMF));
      f = 0;
      for (int k = 0; k < TFB; k++) begin
         s = m * m;
         if ((s >> (2*TMF + 1)) & 1) begin
            f = (f << 1) | 1;
            m = s >> (TMF + 1);
         end else begin
            f = f << 1;
            m = s >> TMF;
         end
         m = m & ((64'sd1 << (TMF + 1)) - 1);
      end
      return (p << TFB) | f;
   endfunction

   // run one conversion; returns latency in cycles
   task automatic run_op(input int x, output int lat);
      @(negedge clk);
      din   = TIW'(x);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after accept", busy, 1);
      lat = 0;
      while (!done && lat < 4*TFB) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      longint exp;
      // R1: state during and after reset
      #(CLK_PERIOD*2 + 1);
      check(!busy && !done && !error && result == 0, "R1 in reset", result, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !error && result == 0, "R1 after reset", {busy, done, error}, 0);

      // exhaustive sweep: R3 R4 R5 R6 R7 R8
      for (int x = 0; x < (1 << TIW); x++) begin
         run_op(x, lat);
         exp = model(x);
         check(lat == TFB, "R3 latency", lat, TFB);
         check(longint'(result) == exp, (x >= (1 << (TMF+1))) ? "R5 R6 result" : "R4 R6 R7 result",
               result, exp);
         check(error == (x == 0), "R8 error flag", error, (x == 0));
         @(negedge clk);
         check(!done, "R3 done one cycle", done, 0);
      end

      // R10: powers of two have zero fraction
      for (int b = 0; b < TIW; b++) begin
         run_op(1 << b, lat);
         check(result[TFB-1:0] == 0 && result[TRW-1:TFB] == TINT'(b), "R10 power of two",
               result, longint'(b) << TFB);
      end

      // R8: error then clear by nonzero
      run_op(0, lat);
      check(error && result == 0, "R8 zero input", result, 0);
      run_op(3, lat);
      check(!error, "R8 error cleared", error, 0);

      // R2: start while busy is ignored
      @(negedge clk);
      din = TIW'(700);
      start = 1'b1;
      @(negedge clk);
      din = TIW'(5);
      lat = 0;
      @(negedge clk);
      lat = 1;
      start = 1'b0;
      while (!done && lat < 4*TFB) begin
         @(negedge clk);
         lat++;
      end
      check(lat == TFB, "R2 latency unchanged", lat, TFB);
      check(longint'(result) == model(700), "R2 result unchanged", result, model(700));

      // R9: result held while idle
      exp = result;
      din = TIW'(1);
      for (int k = 0; k < 5; k++) @(negedge clk);
      check(longint'(result) == exp && !error, "R9 hold", result, exp);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule